// File: doc/BRIEF.md
# Bit-Manipulation Execute Unit

This unit sits in the execute stage of a small 32-bit processor and carries out five operations on flags and single bits: replacing the low byte of control register 0, clearing selected low-byte flags of that register, testing one bit of a source register into a condition flag, and setting or clearing one bit of a byte in memory. The decoder hands it an operation code, an 8-bit immediate (whose low three bits are the bit number for bit operations), a signed 16-bit displacement and the source register value. The unit also returns the program-counter step of the instruction it completed.

Register-only operations finish in the cycle they are presented. Memory bit operations run an atomic read-modify-write on a byte-wide port at source plus sign-extended displacement. While that runs the unit holds a busy signal so the pipeline stalls, and it holds a lock output so that no other master can touch the byte between the read and the write.

Top module: `bitx_unit`

## Requirements
- R1: After reset, cr0 is 0, cond is 0, busy and done are 0, and mem_rd and mem_wr are 0.
- R2: Set-flags (op 1), when accepted, loads cr0 with the 8-bit immediate zero-extended. done is high in the accept cycle with pc_inc 2, and cr0 shows the new value from the next cycle.
- R3: Clear-flags (op 0) loads cr0 with cr0 AND NOT (zero-extended immediate), so only bits 7:0 can be cleared and bits 31:8 are kept. done is high in the accept cycle with pc_inc 2.
- R4: Test-bit (op 4) sets cond to bit (7−n) of src, where n = imm[2:0]. It makes no memory request, and it pulses done in the accept cycle with pc_inc 2.
- R5: Bit number n = imm[2:0] selects byte bit 7−n, so n=0 addresses bit 7. imm[7:3] is ignored by the bit operations.
- R6: Set-bit (op 2) reads one byte at address src + sign-extended disp, modulo 2^32. It then writes back to the same address that byte OR the one-hot mask at position 7−n.
- R7: Clear-bit (op 3) uses the same addressing and writes back the byte AND the inverted mask.
- R8: A memory operation holds mem_rd until mem_ready, then holds mem_wr until mem_ready, then pulses done for one cycle with pc_inc 4. busy is high from the cycle after acceptance through the done cycle and low after it. pc_inc is 0 whenever done is low.
- R9: mem_lock is high in every cycle in which mem_rd or mem_wr is high.
- R10: start is ignored while busy is high. Op codes 5, 6 and 7 produce no done, no memory request and no change of cr0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation presented this cycle |
| op | input | 3 | Operation code (0 clear-flags, 1 set-flags, 2 set-bit, 3 clear-bit, 4 test-bit) |
| imm | input | 8 | Immediate; bits 2:0 are the bit number for bit operations |
| disp | input | 16 | Signed address displacement |
| src | input | 32 | Source register value |
| busy | output | 1 | Memory operation in progress; stall |
| done | output | 1 | Operation completes this cycle |
| pc_inc | output | 3 | Program-counter step of the completing operation |
| cr0 | output | 32 | Control register 0 |
| cond | output | 1 | Condition flag |
| mem_addr | output | 32 | Byte address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready during a read |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_lock | output | 1 | Byte locked for the read-modify-write |

## Verification
Register operations give done and pc_inc combinationally in the cycle start is accepted. Their cr0 and cond results appear one clock later, so the monitor compares done and pc_inc at the falling edge of the accept cycle and compares cr0 and cond at the next falling edge. For memory operations the bench memory adds 0 to 3 wait cycles per request. The monitor records each accepted read and write at the falling edge where mem_ready is high, and it compares address, write data, request counts and pc_inc when done appears, whatever the latency was. A busy-time start and an undefined op code are injected with no queued entry, so any done they cause is an unexpected result, and cr0 is compared with the model afterwards.

// File: rtl/bitx_pkg.sv
package bitx_pkg;
  localparam int XLEN   = 32;
  localparam int DISP_W = 16;
  localparam int IMM_W  = 8;
  localparam int BYTE_W = 8;
  localparam int BITN_W = $clog2(BYTE_W);
  localparam int PCI_W  = 3;

  localparam logic [2:0] OPC_CLRF = 3'd0;
  localparam logic [2:0] OPC_SETF = 3'd1;
  localparam logic [2:0] OPC_BSET = 3'd2;
  localparam logic [2:0] OPC_BCLR = 3'd3;
  localparam logic [2:0] OPC_BTST = 3'd4;

  localparam logic [PCI_W-1:0] STEP_SHORT = 3'd2;
  localparam logic [PCI_W-1:0] STEP_LONG  = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} seq_e;

  // one-hot mask, bit number counted from the top of the byte
  function automatic logic [BYTE_W-1:0] bit_mask(input logic [BITN_W-1:0] n);
    logic [BYTE_W-1:0] top;
    top = {1'b1, {(BYTE_W-1){1'b0}}};
    return top >> n;
  endfunction

  function automatic logic [XLEN-1:0] eff_addr(input logic [XLEN-1:0] base,
                                               input logic [DISP_W-1:0] d);
    return base + {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [BYTE_W-1:0] modify_byte(input logic [BYTE_W-1:0] d,
                                                    input logic [BYTE_W-1:0] m,
                                                    input logic set);
    return set ? (d | m) : (d & ~m);
  endfunction

  function automatic logic test_bit(input logic [XLEN-1:0] v,
                                    input logic [BITN_W-1:0] n);
    logic [XLEN-1:0] sh;
    sh = v >> (XLEN'(BYTE_W - 1) - XLEN'(n));
    return sh[0];
  endfunction
endpackage

// File: rtl/bitx_regops.sv
module bitx_regops
  import bitx_pkg::*;
(
  input  logic [2:0]       op,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  cr0_q,
  output logic             is_reg,
  output logic             is_mem,
  output logic             wr_cr0,
  output logic             wr_cond,
  output logic [XLEN-1:0]  cr0_nxt,
  output logic             cond_nxt
);
  logic [XLEN-1:0] imm_ext;
  assign imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};

  always_comb begin
    wr_cr0   = 1'b0;
    wr_cond  = 1'b0;
    is_mem   = 1'b0;
    cr0_nxt  = cr0_q;
    cond_nxt = test_bit(src, imm[BITN_W-1:0]);
    case (op)
      OPC_CLRF: begin wr_cr0 = 1'b1; cr0_nxt = cr0_q & ~imm_ext; end
      OPC_SETF: begin wr_cr0 = 1'b1; cr0_nxt = imm_ext; end
      OPC_BTST: wr_cond = 1'b1;
      OPC_BSET, OPC_BCLR: is_mem = 1'b1;
      default: ;
    endcase
    is_reg = wr_cr0 | wr_cond;
  end

  always_comb begin
    if (is_reg && is_mem) $error("p_class_excl_r10: op both register and memory");
  end
endmodule

// File: rtl/bitx_memseq.sv
module bitx_memseq
  import bitx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              set_op,
  input  logic [XLEN-1:0]   addr_in,
  input  logic [BITN_W-1:0] bitn,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_lock,
  output logic              busy,
  output logic              fin
);
  seq_e              state;
  logic [XLEN-1:0]   addr_q;
  logic [BYTE_W-1:0] mask_q;
  logic [BYTE_W-1:0] data_q;
  logic              set_q;

  logic rd_ack, wr_ack;
  assign rd_ack = (state == S_READ)  && mem_ready;
  assign wr_ack = (state == S_WRITE) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      mask_q <= '0;
      data_q <= '0;
      set_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state  <= S_READ;
          addr_q <= addr_in;
          mask_q <= bit_mask(bitn);
          set_q  <= set_op;
        end
        S_READ: if (rd_ack) begin
          data_q <= modify_byte(mem_rdata, mask_q, set_q);
          state  <= S_WRITE;
        end
        S_WRITE: if (wr_ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = (state == S_READ);
  assign mem_wr    = (state == S_WRITE);
  assign mem_wdata = data_q;
  assign mem_lock  = (state == S_READ) || (state == S_WRITE);
  assign busy      = (state != S_IDLE);
  assign fin       = (state == S_DONE);

  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_lock_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> mem_lock);
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
  p_rd_to_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ready) |=> (mem_wr && $stable(mem_addr)));
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_wdata)));
  p_wr_to_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready) |=> fin);
  p_fin_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
endmodule

// File: rtl/bitx_unit.sv
module bitx_unit
  import bitx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   src,
  output logic              busy,
  output logic              done,
  output logic [PCI_W-1:0]  pc_inc,
  output logic [XLEN-1:0]   cr0,
  output logic              cond,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              mem_lock
);
  logic [XLEN-1:0] cr0_q, cr0_nxt;
  logic            cond_q, cond_nxt;
  logic            is_reg, is_mem, wr_cr0, wr_cond;
  logic            accept, reg_fire, mem_go, seq_fin;

  bitx_regops u_reg (
    .op(op), .imm(imm), .src(src), .cr0_q(cr0_q),
    .is_reg(is_reg), .is_mem(is_mem), .wr_cr0(wr_cr0), .wr_cond(wr_cond),
    .cr0_nxt(cr0_nxt), .cond_nxt(cond_nxt)
  );

  assign accept   = start && !busy;
  assign reg_fire = accept && is_reg;
  assign mem_go   = accept && is_mem;

  bitx_memseq u_seq (
    .clk(clk), .rst_n(rst_n), .go(mem_go), .set_op(op == OPC_BSET),
    .addr_in(eff_addr(src, disp)), .bitn(imm[BITN_W-1:0]),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_lock(mem_lock), .busy(busy), .fin(seq_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q  <= '0;
      cond_q <= 1'b0;
    end else if (reg_fire) begin
      if (wr_cr0)  cr0_q  <= cr0_nxt;
      if (wr_cond) cond_q <= cond_nxt;
    end
  end

  assign done   = reg_fire || seq_fin;
  assign pc_inc = seq_fin ? STEP_LONG : (reg_fire ? STEP_SHORT : '0);
  assign cr0    = cr0_q;
  assign cond   = cond_q;

  p_cr0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(cr0_q));
  p_cond_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(cond_q));
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cr0_q));
  p_step_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pc_inc == STEP_LONG) == busy));
  p_reg_nomem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fire |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/bitx_unit_test.sv
module bitx_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  imm = '0;
  logic [15:0] disp = '0;
  logic [31:0] src = '0;
  logic        busy, done, cond, mem_rd, mem_wr, mem_lock, mem_ready;
  logic [2:0]  pc_inc;
  logic [31:0] cr0, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #(CLK_P/2) clk = ~clk;

  bitx_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .imm(imm), .disp(disp),
    .src(src), .busy(busy), .done(done), .pc_inc(pc_inc), .cr0(cr0), .cond(cond),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_lock(mem_lock)
  );

  // memory model with programmable wait cycles
  logic [7:0] mem [64];
  logic [7:0] model_mem [64];
  int lat = 0;
  int wcnt = 0;
  assign mem_ready = (mem_rd || mem_wr) && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk) begin
    if (mem_rd || mem_wr) begin
      if (mem_ready) begin
        wcnt <= 0;
        if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
      end else wcnt <= wcnt + 1;
    end
  end

  typedef struct {
    logic [2:0]  pc;
    logic [31:0] cr0;
    logic        cond;
    logic        is_mem;
    logic [31:0] addr;
    logic [7:0]  wdata;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t pend;
  logic pend_v = 1'b0;
  int nchk = 0, nfail = 0, issued = 0, completed = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_addr, wr_addr;
  logic [7:0]  wr_data;
  logic [31:0] model_cr0 = '0;
  logic        model_cond = 1'b0;
  logic        finished = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  // monitor: samples at falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr) chk(mem_lock, "R9 lock during request", 32'(mem_lock), 32'd1);
      if (mem_rd && mem_ready) begin rd_cnt++; rd_addr = mem_addr; end
      if (mem_wr && mem_ready) begin wr_cnt++; wr_addr = mem_addr; wr_data = mem_wdata; end
      if (pend_v) begin
        chk(cr0 == pend.cr0, {pend.tag, " cr0"}, cr0, pend.cr0);
        chk(cond == pend.cond, {pend.tag, " cond"}, 32'(cond), 32'(pend.cond));
        chk(!busy, "R8 busy low after done", 32'(busy), 32'd0);
        pend_v = 1'b0;
        completed++;
      end
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 32'(done), 32'd0);
        end else begin
          pend = q.pop_front();
          pend_v = 1'b1;
          chk(pc_inc == pend.pc, {pend.tag, " pc_inc"}, 32'(pc_inc), 32'(pend.pc));
          if (pend.is_mem) begin
            chk(busy, "R8 busy in done cycle", 32'(busy), 32'd1);
            chk(rd_cnt == 1 && wr_cnt == 1, {pend.tag, " one read one write"},
                32'(rd_cnt * 16 + wr_cnt), 32'h11);
            chk(rd_addr == pend.addr, {pend.tag, " read addr"}, rd_addr, pend.addr);
            chk(wr_addr == pend.addr, {pend.tag, " write addr"}, wr_addr, pend.addr);
            chk(wr_data == pend.wdata, {pend.tag, " write data"}, 32'(wr_data), 32'(pend.wdata));
          end else begin
            chk(rd_cnt == 0 && wr_cnt == 0, "R4 no memory access", 32'(rd_cnt + wr_cnt), 32'd0);
          end
          rd_cnt = 0;
          wr_cnt = 0;
        end
      end
    end
  end

  // driver: computes the expected result, queues it, drives the op
  task automatic issue(input logic [2:0] o, input logic [7:0] im, input logic [15:0] d,
                       input logic [31:0] s, input string tag);
    exp_t e;
    int k;
    logic [31:0] a;
    logic [7:0] m;
    e.is_mem = 1'b0; e.addr = '0; e.wdata = '0; e.tag = tag;
    k = 7 - int'(im[2:0]);
    m = 8'd1 << k;
    case (o)
      3'd1: model_cr0 = {24'd0, im};
      3'd0: model_cr0 = model_cr0 & ~{24'd0, im};
      3'd4: model_cond = s[k];
      default: begin
        a = s + {{16{d[15]}}, d};
        e.is_mem = 1'b1;
        e.addr = a;
        e.wdata = (o == 3'd2) ? (model_mem[a[5:0]] | m) : (model_mem[a[5:0]] & ~m);
        model_mem[a[5:0]] = e.wdata;
      end
    endcase
    e.pc = e.is_mem ? 3'd4 : 3'd2;
    e.cr0 = model_cr0;
    e.cond = model_cond;
    q.push_back(e);
    issued++;
    @(posedge clk); #1;
    start = 1'b1; op = o; imm = im; disp = d; src = s;
    @(posedge clk); #1;
    start = 1'b0;
    while (completed != issued) @(negedge clk);
    @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 37) ^ 8'h5A;
      model_mem[i] = mem[i];
    end
    #(CLK_P * 3 + 2);
    // R1 reset state
    chk(cr0 == 0, "R1 cr0 reset", cr0, 32'd0);
    chk(!cond && !busy && !done, "R1 flags reset", {29'd0, cond, busy, done}, 32'd0);
    chk(!mem_rd && !mem_wr, "R1 no request", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk);

    issue(3'd1, 8'hC3, 16'd0, 32'd0, "R2 set-flags C3");
    issue(3'd0, 8'h81, 16'd0, 32'd0, "R3 clear-flags 81");
    issue(3'd1, 8'hFF, 16'd0, 32'd0, "R2 set-flags FF");
    issue(3'd0, 8'h0F, 16'd0, 32'd0, "R3 clear-flags 0F");
    issue(3'd4, 8'h00, 16'd0, 32'h0000_0080, "R5 test-bit n0 msb");
    issue(3'd4, 8'h07, 16'd0, 32'h0000_0001, "R4 test-bit n7 lsb");
    issue(3'd4, 8'h00, 16'd0, 32'h0000_0001, "R4 test-bit n0 clear");
    issue(3'd4, 8'hF8, 16'd0, 32'hFFFF_FF7F, "R5 test-bit imm high bits ignored");
    issue(3'd4, 8'h0A, 16'd0, 32'h0000_0020, "R5 test-bit n2 via imm[2:0]");

    lat = 0;
    issue(3'd2, 8'h03, 16'h0005, 32'h0000_0010, "R6 set-bit lat0");
    lat = 2;
    issue(3'd3, 8'h00, 16'hFFF0, 32'h0000_0120, "R7 clear-bit negative disp");
    lat = 1;
    issue(3'd2, 8'hF7, 16'h0020, 32'hFFFF_FFF0, "R6 set-bit address wrap");
    lat = 3;
    issue(3'd3, 8'h05, 16'h0005, 32'h0000_0010, "R7 clear-bit lat3");

    // R10 start while busy is ignored
    fork
      issue(3'd2, 8'h01, 16'h0002, 32'h0000_0030, "R8 set-bit with busy poke");
      begin
        repeat (3) @(posedge clk);
        #1; start = 1'b1; op = 3'd1; imm = 8'hAA;
        @(posedge clk); #1; start = 1'b0;
      end
    join
    chk(cr0 == model_cr0, "R10 cr0 after busy poke", cr0, model_cr0);

    // R10 undefined op code
    @(posedge clk); #1; start = 1'b1; op = 3'd6; imm = 8'hFF;
    @(posedge clk); #1; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd, "R10 undefined op no activity", {30'd0, busy, mem_rd}, 32'd0);
    chk(cr0 == model_cr0, "R10 cr0 after undefined op", cr0, model_cr0);
    issue(3'd0, 8'h30, 16'd0, 32'd0, "R3 clear-flags after ignores");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule